// File: doc/BRIEF.md
# Saturating Monitoring Counter Bank

This block holds a set of activity and dead-time counters for a detector front end. Every counter has its own single-cycle event input in the system clock domain. It counts up by one per event and stops at full scale instead of wrapping. A free-running interval timer marks the end of each accumulation period, nominally one second. On that mark every counter value moves into a shadow readout register, and the counter begins the new period from zero.

For production and in-service test, a serial control port reaches every counter through one shift chain. Software shifts a pattern in and then strobes a parallel load, which presets all counters at once. A capture strobe copies either the live counters or the shadow registers into the chain, and software then shifts the result out. A test increment command steps every counter together. After a preload near full scale, a few such steps reach the saturation point without any event traffic.

The bank has two counter widths. The number of wide and narrow counters is set by parameters, and so are both widths and the interval length in clock cycles.

Top module: `mon_counter_bank`

## Requirements
- R1: After reset, every counter, every shadow register and the shift chain hold zero, and both `shift_o` and `tick_o` are low.
- R2: A one-cycle pulse on `event_i[k]` raises counter k by exactly one and leaves every other counter unchanged. Indices 0 to N_WIDE-1 are the wide counters and the indices above them are the narrow counters.
- R3: A counter at its all-ones value (2^W-1 for its width W) stays there on any further event or test increment. This holds for both widths.
- R4: While `run_i` is high, `tick_o` pulses for one cycle every TICK_CYCLES cycles. The first pulse is visible TICK_CYCLES-1 clock edges after `run_i` rises. While `run_i` is low, `tick_o` stays low and the period count restarts from zero.
- R5: On a tick cycle each shadow register takes the counter value from before that cycle. The counter then restarts at 0, or at 1 if its event arrives in that same cycle.
- R6: A one-cycle pulse on `test_inc_i` raises every non-saturated counter by one. If an event is coincident with it, the counter still rises by only one.
- R7: The chain shifts by one bit per cycle while `shift_en_i` is high. `shift_i` enters at the bottom and `shift_o` is the top bit. From top to bottom the chain holds wide counter 0 to the last narrow counter, each counter most significant bit first.
- R8: A `load_i` strobe copies the chain into all counters. It takes priority over an event, a tick or a test increment in the same cycle.
- R9: `capture_live_i` copies the live counters into the chain and `capture_snap_i` copies the shadow registers into it. A live capture wins over a shadow capture, and either capture wins over a shift. With no strobe and no shift, the chain holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | N_WIDE+N_NARROW | One-cycle event pulses, one per counter |
| run_i | input | 1 | Enables the interval timer |
| test_inc_i | input | 1 | Collective increment pulse |
| shift_en_i | input | 1 | Shift the chain by one bit |
| shift_i | input | 1 | Serial data into the chain bottom |
| load_i | input | 1 | Parallel load from the chain into the counters |
| capture_live_i | input | 1 | Parallel capture of the live counters into the chain |
| capture_snap_i | input | 1 | Parallel capture of the shadow registers into the chain |
| shift_o | output | 1 | Serial data from the chain top |
| tick_o | output | 1 | Interval end pulse |

## Verification
Several rules are checked on every cycle by the assertions:
- a full counter holds its value;
- a plain increment adds exactly one;
- an idle counter is stable;
- a tick restarts the counter and fills the shadow register with the old count;
- a load takes the chain value;
- the chain shifts, captures and holds as its strobes command;
- ticks never come back to back.

Other behaviour shows only at the ports, in the bench's scenarios. These cover the bit order of the serial chain, the period and restart of the interval timer, the single count for an event that meets a test increment, load priority over an event, live-over-shadow capture priority, and saturation reached from a preload near full scale.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  typedef enum logic [1:0] {
    CHAIN_HOLD  = 2'd0,
    CHAIN_SHIFT = 2'd1,
    CHAIN_LIVE  = 2'd2,
    CHAIN_SNAP  = 2'd3
  } chain_op_e;

  function automatic chain_op_e chain_op(input logic cap_live, input logic cap_snap,
                                         input logic shift_en);
    if (cap_live)      return CHAIN_LIVE;
    else if (cap_snap) return CHAIN_SNAP;
    else if (shift_en) return CHAIN_SHIFT;
    else               return CHAIN_HOLD;
  endfunction

endpackage

// File: rtl/mcb_interval_timer.sv
module mcb_interval_timer #(
  parameter int unsigned TICK_CYCLES = 20_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_timer_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/mcb_sat_counter.sv
module mcb_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] shadow_o
);
  logic [W-1:0] count_q, shadow_q;
  logic         full;

  assign full = &count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             count_q <= '0;
    else if (load_i)         count_q <= load_val_i;
    else if (tick_i)         count_q <= W'(inc_i);
    else if (inc_i && !full) count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (tick_i) shadow_q <= count_q;
  end

  assign count_o  = count_q;
  assign shadow_o = shadow_q;

  assert_sat_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !load_i && !tick_i) |=> (&count_q));

  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !full && !load_i && !tick_i) |=> (count_q == $past(count_q) + 1'b1));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i && !tick_i) |=> $stable(count_q));

  assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (count_q == W'($past(inc_i))));

  assert_shadow_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (shadow_q == $past(count_q)));

  assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(load_val_i)));

endmodule

// File: rtl/mon_counter_bank.sv
module mon_counter_bank
  import mcb_pkg::*;
#(
  parameter int unsigned N_WIDE      = 2,
  parameter int unsigned N_NARROW    = 2,
  parameter int unsigned W_WIDE      = 24,
  parameter int unsigned W_NARROW    = 16,
  parameter int unsigned TICK_CYCLES = 20_000_000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_WIDE+N_NARROW-1:0]   event_i,
  input  logic                         run_i,
  input  logic                         test_inc_i,
  input  logic                         shift_en_i,
  input  logic                         shift_i,
  input  logic                         load_i,
  input  logic                         capture_live_i,
  input  logic                         capture_snap_i,
  output logic                         shift_o,
  output logic                         tick_o
);
  localparam int unsigned N_CNT   = N_WIDE + N_NARROW;
  localparam int unsigned WIDE_SPAN = N_WIDE * W_WIDE;
  localparam int unsigned CHAIN_W = WIDE_SPAN + N_NARROW * W_NARROW;

  logic [CHAIN_W-1:0] chain_q, live_flat, snap_flat;
  logic [N_CNT-1:0]   inc;
  logic               tick;
  chain_op_e          op;

  mcb_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .tick_o (tick)
  );

  // event and test increment merge: coincident pulses count once
  assign inc = event_i | {N_CNT{test_inc_i}};

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    localparam int unsigned HI = CHAIN_W - 1 - i * W_WIDE;
    localparam int unsigned LO = HI - W_WIDE + 1;
    mcb_sat_counter #(.W(W_WIDE)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_i),
      .load_val_i (chain_q[HI:LO]),
      .tick_i     (tick),
      .inc_i      (inc[i]),
      .count_o    (live_flat[HI:LO]),
      .shadow_o   (snap_flat[HI:LO])
    );
  end

  for (genvar j = 0; j < N_NARROW; j++) begin : g_narrow
    localparam int unsigned HI = CHAIN_W - 1 - WIDE_SPAN - j * W_NARROW;
    localparam int unsigned LO = HI - W_NARROW + 1;
    mcb_sat_counter #(.W(W_NARROW)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_i),
      .load_val_i (chain_q[HI:LO]),
      .tick_i     (tick),
      .inc_i      (inc[N_WIDE+j]),
      .count_o    (live_flat[HI:LO]),
      .shadow_o   (snap_flat[HI:LO])
    );
  end

  assign op = chain_op(capture_live_i, capture_snap_i, shift_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else begin
      unique case (op)
        CHAIN_LIVE:  chain_q <= live_flat;
        CHAIN_SNAP:  chain_q <= snap_flat;
        CHAIN_SHIFT: chain_q <= {chain_q[CHAIN_W-2:0], shift_i};
        default:     chain_q <= chain_q;
      endcase
    end
  end

  assign shift_o = chain_q[CHAIN_W-1];
  assign tick_o  = tick;

  assert_shift_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !capture_live_i && !capture_snap_i) |=> (shift_o == $past(chain_q[CHAIN_W-2])));

  assert_live_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_live_i |=> (chain_q == $past(live_flat)));

  assert_snap_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_snap_i && !capture_live_i) |=> (chain_q == $past(snap_flat)));

  assert_chain_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !capture_live_i && !capture_snap_i) |=> $stable(chain_q));

endmodule

// File: tb/mon_counter_bank_bench.sv
module mon_counter_bank_bench;
  localparam int NW = 2, NN = 2, WW = 24, WN = 16, TICK = 40;
  localparam int NC = NW + NN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] ev = '0;
  logic run = 0, tinc = 0, sh_en = 0, sh_in = 0, load = 0, cap_l = 0, cap_s = 0;
  logic sh_out, tick;

  int total = 0, bad = 0;

  typedef struct { string tag; logic [31:0] v; } item_t;
  item_t       exp_q[$];
  logic [31:0] act_q[$];
  event        word_ev;

  always #10 clk = ~clk;

  mon_counter_bank #(.N_WIDE(NW), .N_NARROW(NN), .W_WIDE(WW), .W_NARROW(WN),
                     .TICK_CYCLES(TICK)) u_mon_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .run_i(run), .test_inc_i(tinc),
    .shift_en_i(sh_en), .shift_i(sh_in), .load_i(load), .capture_live_i(cap_l),
    .capture_snap_i(cap_s), .shift_o(sh_out), .tick_o(tick));

  function automatic int width_of(int k);
    return (k < NW) ? WW : WN;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as words come out of the chain
  initial forever begin
    @(word_ev);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      logic [31:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      check(e.tag, a, e.v);
    end
  end

  task automatic expect_words(string tag, logic [31:0] v0, logic [31:0] v1,
                              logic [31:0] v2, logic [31:0] v3);
    exp_q.push_back('{tag, v0});
    exp_q.push_back('{tag, v1});
    exp_q.push_back('{tag, v2});
    exp_q.push_back('{tag, v3});
  endtask

  task automatic read_chain(logic live, logic snap);
    @(negedge clk); cap_l = live; cap_s = snap;
    @(negedge clk); cap_l = 0; cap_s = 0; sh_en = 1;
    for (int k = 0; k < NC; k++) begin
      logic [31:0] val = '0;
      for (int b = 0; b < width_of(k); b++) begin
        val = (val << 1) | 32'(sh_out);
        @(negedge clk);
      end
      act_q.push_back(val);
      ->word_ev;
    end
    sh_en = 0;
    @(negedge clk);
  endtask

  task automatic preload(logic [31:0] v0, logic [31:0] v1, logic [31:0] v2,
                         logic [31:0] v3, logic [NC-1:0] ev_at_load);
    logic [31:0] vals[NC];
    vals[0] = v0; vals[1] = v1; vals[2] = v2; vals[3] = v3;
    for (int k = 0; k < NC; k++)
      for (int b = width_of(k) - 1; b >= 0; b--) begin
        @(negedge clk); sh_en = 1; sh_in = vals[k][b];
      end
    @(negedge clk); sh_en = 0; sh_in = 0; load = 1; ev = ev_at_load;
    @(negedge clk); load = 0; ev = '0;
  endtask

  task automatic pulse_ev(logic [NC-1:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  task automatic pulse_inc(logic [NC-1:0] m);
    @(negedge clk); tinc = 1; ev = m;
    @(negedge clk); tinc = 0; ev = '0;
  endtask

  initial begin : watchdog
    repeat (100_000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int stray;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 shift_o", 32'(sh_out), 0);
    check("R1 tick_o", 32'(tick), 0);
    rst_n = 1;
    expect_words("R1 live", 0, 0, 0, 0);
    read_chain(1, 0);
    expect_words("R1 snap", 0, 0, 0, 0);
    read_chain(0, 1);

    // R2 events per counter
    repeat (3) pulse_ev(4'b0001);
    repeat (5) pulse_ev(4'b0100);
    pulse_ev(4'b1010);
    expect_words("R2 events", 3, 1, 5, 1);
    read_chain(1, 0);

    // R8 preload with coincident event, R7 order
    preload(32'hFFFFFD, 32'h000010, 32'hFFFE, 32'h1234, 4'b0001);
    expect_words("R8 R7 preload order", 32'hFFFFFD, 32'h10, 32'hFFFE, 32'h1234);
    read_chain(1, 0);

    // R6 collective increment, R3 saturation on both widths
    repeat (5) pulse_inc('0);
    expect_words("R6 R3 test inc", 32'hFFFFFF, 32'h15, 32'hFFFF, 32'h1239);
    read_chain(1, 0);
    pulse_inc(4'b1111);
    expect_words("R6 coincident once", 32'hFFFFFF, 32'h16, 32'hFFFF, 32'h123A);
    read_chain(1, 0);
    repeat (2) pulse_ev(4'b0101);
    expect_words("R3 events at full", 32'hFFFFFF, 32'h16, 32'hFFFF, 32'h123A);
    read_chain(1, 0);

    // R4 R5 interval tick
    preload(32'h10, 32'h20, 32'h30, 32'h40, '0);
    @(negedge clk); run = 1; n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 10 * TICK);
    check("R4 first tick delay", n, TICK - 1);
    ev = 4'b0011;                       // events coincide with tick
    n = 0;
    do begin @(negedge clk); ev = '0; n++; end while (!tick && n < 10 * TICK);
    check("R4 tick period", n, TICK);
    run = 0;                            // suppress this tick
    stray = 0;
    repeat (3 * TICK) begin @(negedge clk); if (tick) stray++; end
    check("R4 no tick while idle", stray, 0);
    expect_words("R5 restart with event", 1, 1, 0, 0);
    read_chain(1, 0);
    expect_words("R5 shadow", 32'h10, 32'h20, 32'h30, 32'h40);
    read_chain(0, 1);
    expect_words("R9 live beats snap", 1, 1, 0, 0);
    read_chain(1, 1);

    repeat (2) @(negedge clk);
    check("R9 queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule